// File: doc/BRIEF.md
# Performance Event Counter Unit

A register-mapped monitor that counts hardware events and clock cycles. It holds a small bank of 32-bit event counters, each tied to one line of an event input vector by a programmable type, and a free-running 64-bit cycle counter. Software configures and reads the unit through a single-cycle register port. Reads are combinational from the current state. Writes take effect at the next rising clock edge.

Each event counter is reached indirectly. A selection register picks the counter, and two shared registers then address that counter's event type and count value. A control register holds the global enable, self-clearing reset strobes for the event counters and for the cycle counter, and a divide-by-64 option for the cycle counter. The same register reports how many event counters exist. Count enables, interrupt enables and overflow flags each have a write-one-to-set and a write-one-to-clear address. An interrupt line is raised while any overflowed counter also has its interrupt enabled.

Top module: `perf_counter_unit`

## Requirements
- R1: While control bit 0 (global enable, word address 0) is 0, neither the cycle counter nor any event counter advances.
- R2: A control write with bit 1 set clears every event counter. A control write with bit 2 set clears the cycle counter and its prescaler. Both bits read back as 0.
- R3: With control bit 3 set, the cycle counter advances once per 64 enabled clock cycles. With bit 3 clear, it advances on every enabled cycle.
- R4: A read of the control register (address 0) returns the number of event counters in bits 15:11 and the stored control bits 0, 3, 4 and 5 in place. All other bits read 0, and writes store only bits 5:0.
- R5: The selection register (address 1, low 5 bits) makes the event-type register (address 2, low 8 bits) and the count register (address 3, 32 bits) read and write the selected counter.
- R6: When the selection value is at or beyond the number of counters, addresses 2 and 3 read 0 and writes to them change nothing.
- R7: A write to address 4 sets the count-enable bits given as 1 and leaves the others unchanged. A write to address 5 clears the count-enable bits given as 1. Both addresses read the current enables.
- R8: Addresses 6 and 7 set and clear interrupt-enable bits, and addresses 8 and 9 set and clear overflow flags, by the same one-bit rules. Each pair reads back the current state. A hardware overflow in the same cycle as a clear leaves the flag set.
- R9: An event counter adds one in each cycle where the global enable and its count enable are set and the event input indexed by its type is high. A type at or beyond the event vector width never counts. Wrapping from all ones to zero sets that counter's overflow flag.
- R10: irq_o is high exactly when some counter has both its overflow flag and its interrupt enable set. It stays high until software clears one of them.
- R11: Addresses 10 and 11 return the low and high 32 bits of the 64-bit cycle counter, independent of the selection register.
- R12: The user-access register (address 12) stores only the low 4 bits of a write and reads them back. All upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| evt_i | input | NUM_EVT | Event input vector |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Read data depends only on the current state and addr_i, so its value is due in the same cycle as the address. Every write, count step, reset strobe and overflow flag appears in state one rising edge after the cycle in which it was presented. irq_o follows the flags without any added register. The bench changes inputs on the falling edge and updates its reference model on the rising edge from the inputs held there. It compares rdata_o and irq_o against the model one nanosecond after each falling edge, so every result is sampled exactly one edge after its cause.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int CYC_W = 64;
  localparam int CTRL_W = 6;
  localparam int SEL_W = 5;
  localparam int NFIELD_LSB = 11;

  typedef enum logic [3:0] {
    A_CTRL    = 4'd0,
    A_SEL     = 4'd1,
    A_ETYPE   = 4'd2,
    A_ECNT    = 4'd3,
    A_CEN_SET = 4'd4,
    A_CEN_CLR = 4'd5,
    A_IEN_SET = 4'd6,
    A_IEN_CLR = 4'd7,
    A_OVF_SET = 4'd8,
    A_OVF_CLR = 4'd9,
    A_CYC_LO  = 4'd10,
    A_CYC_HI  = 4'd11,
    A_USER    = 4'd12
  } reg_addr_e;
endpackage

// File: rtl/pcu_bitreg.sv
module pcu_bitreg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // set beats clear so a same-cycle hardware event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
#(
  parameter int DIV_LOG2 = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic              en_o,
  output logic              evt_clr_o,
  output logic [CTRL_W-1:0] ctrl_rd_o,
  output logic [CYC_W-1:0]  cyc_o
);
  logic              div_q;
  logic [1:0]        spare_q;
  logic [DIV_LOG2-1:0] pre_q;
  logic              cyc_clr;

  assign evt_clr_o = wr_i & wdata_i[1];
  assign cyc_clr   = wr_i & wdata_i[2];
  assign ctrl_rd_o = {spare_q, div_q, 2'b00, en_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      div_q   <= 1'b0;
      spare_q <= 2'b00;
    end else if (wr_i) begin
      en_o    <= wdata_i[0];
      div_q   <= wdata_i[3];
      spare_q <= wdata_i[5:4];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_o <= '0;
      pre_q <= '0;
    end else if (cyc_clr) begin
      cyc_o <= '0;
      pre_q <= '0;
    end else if (en_o) begin
      if (!div_q) begin
        cyc_o <= cyc_o + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
        if (&pre_q) cyc_o <= cyc_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcu_evt_cnt.sv
module pcu_evt_cnt #(
  parameter int NUM_EVT = 16,
  parameter int TYPE_W  = 8,
  parameter int CNT_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               clr_i,
  input  logic               wr_type_i,
  input  logic               wr_cnt_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [TYPE_W-1:0]  type_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               wrap_o
);
  logic hit, inc;

  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NUM_EVT; k++)
      if (type_o == TYPE_W'(k)) hit = evt_i[k];
  end

  assign inc    = en_i & hit;
  assign wrap_o = inc & (&cnt_o) & ~clr_i & ~wr_cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        type_o <= '0;
    else if (wr_type_i) type_o <= wdata_i[TYPE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (clr_i)    cnt_o <= '0;
    else if (wr_cnt_i) cnt_o <= wdata_i;
    else if (inc)      cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import pcu_pkg::*;
#(
  parameter int NUM_CNT  = 4,
  parameter int NUM_EVT  = 16,
  parameter int TYPE_W   = 8,
  parameter int DIV_LOG2 = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [3:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq_o
);
  localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam logic [SEL_W-1:0] NUM_L = SEL_W'(NUM_CNT);

  logic               wr;
  logic               en_q, evt_clr;
  logic [CTRL_W-1:0]  ctrl_rd;
  logic [CYC_W-1:0]   cyc_q;
  logic [SEL_W-1:0]   sel_q;
  logic               sel_ok;
  logic [IDX_W-1:0]   sel_idx;
  logic [3:0]         user_q;
  logic [NUM_CNT-1:0] cen_q, ien_q, ovf_q, wrap;
  logic [TYPE_W-1:0]  type_q [NUM_CNT];
  logic [31:0]        cnt_q  [NUM_CNT];
  logic [NUM_CNT-1:0] wmask;

  assign wr      = req_i & we_i;
  assign wmask   = wdata_i[NUM_CNT-1:0];
  assign sel_ok  = sel_q < NUM_L;
  assign sel_idx = sel_q[IDX_W-1:0];

  pcu_ctrl #(.DIV_LOG2(DIV_LOG2)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr && addr_i == A_CTRL),
    .wdata_i   (wdata_i[CTRL_W-1:0]),
    .en_o      (en_q),
    .evt_clr_o (evt_clr),
    .ctrl_rd_o (ctrl_rd),
    .cyc_o     (cyc_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      user_q <= '0;
    end else if (wr) begin
      if (addr_i == A_SEL)  sel_q  <= wdata_i[SEL_W-1:0];
      if (addr_i == A_USER) user_q <= wdata_i[3:0];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic hit_sel;
    assign hit_sel = sel_ok && (sel_q == SEL_W'(i));
    pcu_evt_cnt #(.NUM_EVT(NUM_EVT), .TYPE_W(TYPE_W), .CNT_W(32)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_q & cen_q[i]),
      .clr_i     (evt_clr),
      .wr_type_i (wr && addr_i == A_ETYPE && hit_sel),
      .wr_cnt_i  (wr && addr_i == A_ECNT && hit_sel),
      .wdata_i   (wdata_i),
      .evt_i     (evt_i),
      .type_o    (type_q[i]),
      .cnt_o     (cnt_q[i]),
      .wrap_o    (wrap[i])
    );
  end

  pcu_bitreg #(.W(NUM_CNT)) u_cen (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i ((wr && addr_i == A_CEN_SET) ? wmask : '0),
    .clr_i ((wr && addr_i == A_CEN_CLR) ? wmask : '0),
    .q_o   (cen_q)
  );

  pcu_bitreg #(.W(NUM_CNT)) u_ien (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i ((wr && addr_i == A_IEN_SET) ? wmask : '0),
    .clr_i ((wr && addr_i == A_IEN_CLR) ? wmask : '0),
    .q_o   (ien_q)
  );

  pcu_bitreg #(.W(NUM_CNT)) u_ovf (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (wrap | ((wr && addr_i == A_OVF_SET) ? wmask : '0)),
    .clr_i ((wr && addr_i == A_OVF_CLR) ? wmask : '0),
    .q_o   (ovf_q)
  );

  assign irq_o = |(ovf_q & ien_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[CTRL_W-1:0] = ctrl_rd;
        rdata_o[NFIELD_LSB +: SEL_W] = NUM_L;
      end
      A_SEL:     rdata_o[SEL_W-1:0] = sel_q;
      A_ETYPE:   if (sel_ok) rdata_o[TYPE_W-1:0] = type_q[sel_idx];
      A_ECNT:    if (sel_ok) rdata_o = cnt_q[sel_idx];
      A_CEN_SET, A_CEN_CLR: rdata_o[NUM_CNT-1:0] = cen_q;
      A_IEN_SET, A_IEN_CLR: rdata_o[NUM_CNT-1:0] = ien_q;
      A_OVF_SET, A_OVF_CLR: rdata_o[NUM_CNT-1:0] = ovf_q;
      A_CYC_LO:  rdata_o = cyc_q[31:0];
      A_CYC_HI:  rdata_o = cyc_q[63:32];
      A_USER:    rdata_o[3:0] = user_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pcu_sva.sv
module pcu_sva
  import pcu_pkg::*;
#(
  parameter int NUM_CNT = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [3:0]         addr_i,
  input logic [31:0]        wdata_i,
  input logic [31:0]        rdata_o,
  input logic               irq_o,
  input logic               en_q,
  input logic [CYC_W-1:0]   cyc_q,
  input logic [SEL_W-1:0]   sel_q,
  input logic [NUM_CNT-1:0] cen_q,
  input logic [NUM_CNT-1:0] ovf_q
);
  logic wr;
  assign wr = req_i & we_i;

  p_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !(wr && addr_i == A_CTRL)) |=> $stable(cyc_q));

  p_nfield_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTRL) |-> (rdata_o[15:11] == 5'(NUM_CNT)));

  p_oor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((addr_i == A_ETYPE || addr_i == A_ECNT) && sel_q >= 5'(NUM_CNT)) |-> (rdata_o == 32'd0));

  p_cen_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_CEN_SET) |=>
      ((cen_q & $past(wdata_i[NUM_CNT-1:0])) == $past(wdata_i[NUM_CNT-1:0])));

  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && addr_i == A_OVF_CLR) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  p_irq_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(wr && (addr_i == A_IEN_CLR || addr_i == A_OVF_CLR))) |=> irq_o);
endmodule

bind perf_counter_unit pcu_sva #(.NUM_CNT(NUM_CNT)) u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .en_q    (en_q),
  .cyc_q   (cyc_q),
  .sel_q   (sel_q),
  .cen_q   (cen_q),
  .ovf_q   (ovf_q)
);

// File: tb/perf_counter_unit_test.sv
`timescale 1ns/1ps
module perf_counter_unit_test;
  localparam int NUM = 4;
  localparam int NEV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic [NEV-1:0] evt = '0;
  logic irq;

  int checks = 0, errors = 0;
  int evt_mode = 2;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  perf_counter_unit #(.NUM_CNT(NUM), .NUM_EVT(NEV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  // reference model state
  bit          m_en, m_div;
  logic [1:0]  m_spare;
  int          m_sel, m_pre;
  int          m_type [NUM];
  logic [31:0] m_cnt [NUM];
  logic [NUM-1:0] m_cen, m_ien, m_ovf, m_wrap;
  logic [63:0] m_cyc;
  logic [3:0]  m_user;
  bit          t_wr;
  int          t_a;

  function automatic bit m_hit(int i);
    return (m_type[i] < NEV) ? evt[m_type[i]] : 1'b0;
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    logic [31:0] v = 32'd0;
    case (a)
      0: begin v[0] = m_en; v[3] = m_div; v[5:4] = m_spare; v[15:11] = 5'(NUM); end
      1: v = 32'(m_sel);
      2: v = (m_sel < NUM) ? 32'(m_type[m_sel]) : 32'd0;
      3: v = (m_sel < NUM) ? m_cnt[m_sel] : 32'd0;
      4, 5: v = 32'(m_cen);
      6, 7: v = 32'(m_ien);
      8, 9: v = 32'(m_ovf);
      10: v = m_cyc[31:0];
      11: v = m_cyc[63:32];
      12: v = 32'(m_user);
      default: v = 32'd0;
    endcase
    return v;
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R4";  1, 2, 3: return "R5";  4, 5: return "R7";
      6, 7, 8, 9: return "R8"; 10, 11: return "R11"; 12: return "R12";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_div = 0; m_spare = 0; m_sel = 0; m_pre = 0;
      m_cen = 0; m_ien = 0; m_ovf = 0; m_cyc = 0; m_user = 0;
      for (int i = 0; i < NUM; i++) begin m_type[i] = 0; m_cnt[i] = 0; end
    end else begin
      t_wr = req && we;
      t_a = int'(addr);
      m_wrap = '0;
      for (int i = 0; i < NUM; i++) begin
        if (t_wr && t_a == 0 && wdata[1]) m_cnt[i] = 0;
        else if (t_wr && t_a == 3 && m_sel == i) m_cnt[i] = wdata;
        else if (m_en && m_cen[i] && m_hit(i)) begin
          if (m_cnt[i] == 32'hFFFF_FFFF) m_wrap[i] = 1'b1;
          m_cnt[i] = m_cnt[i] + 32'd1;
        end
      end
      if (t_wr && t_a == 0 && wdata[2]) begin m_cyc = 0; m_pre = 0; end
      else if (m_en) begin
        if (!m_div) m_cyc = m_cyc + 64'd1;
        else if (m_pre == 63) begin m_pre = 0; m_cyc = m_cyc + 64'd1; end
        else m_pre = m_pre + 1;
      end
      if (t_wr && t_a == 9) m_ovf = m_ovf & ~wdata[NUM-1:0];
      if (t_wr && t_a == 8) m_ovf = m_ovf | wdata[NUM-1:0];
      m_ovf = m_ovf | m_wrap;
      if (t_wr) begin
        case (t_a)
          0: begin m_en = wdata[0]; m_div = wdata[3]; m_spare = wdata[5:4]; end
          1: m_sel = int'(wdata[4:0]);
          2: if (m_sel < NUM) m_type[m_sel] = int'(wdata[7:0]);
          4: m_cen = m_cen | wdata[NUM-1:0];
          5: m_cen = m_cen & ~wdata[NUM-1:0];
          6: m_ien = m_ien | wdata[NUM-1:0];
          7: m_ien = m_ien & ~wdata[NUM-1:0];
          12: m_user = wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // event stimulus and per-cycle comparison
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (evt_mode)
      0: evt <= lfsr;
      1: evt <= '1;
      default: evt <= '0;
    endcase
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      check("R10 irq", 32'(irq), 32'(m_ovf & m_ien) != 0 ? 32'd1 : 32'd0);
      check({tag_of(int'(addr)), " rdata"}, rdata, exp_rd(int'(addr)));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = 4'(a); wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic look(int a, string tag);
    @(negedge clk); req = 1; we = 0; addr = 4'(a);
    #1 check(tag, rdata, exp_rd(a));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R4: reset state of the control register, counter count field
    look(0, "R4 reset ctrl");
    check("R4 literal", rdata, 32'h0000_2000);
    look(10, "R11 cyc reset");
    look(8, "R8 ovf reset");
    // R4/R2: only low 6 bits stored, strobes read back 0
    wr(0, 32'hFFFF_FFFE);
    look(0, "R4 low6 stored");
    check("R2 strobes read 0", rdata & 32'h6, 32'h0);
    wr(0, 32'h0);
    // R12
    wr(12, 32'hFFFF_FFFD);
    look(12, "R12 user low4");
    check("R12 literal", rdata, 32'hD);
    // R5: indirect access
    wr(1, 1); wr(2, 3); wr(3, 5);
    look(2, "R5 type sel1"); look(3, "R5 cnt sel1");
    wr(1, 2); wr(2, 4); wr(3, 32'h100);
    wr(1, 0); wr(2, 200);
    look(2, "R5 type sel0");
    // R6: out of range
    wr(1, 7); wr(2, 9); wr(3, 32'h55);
    look(2, "R6 oor type"); look(3, "R6 oor cnt");
    check("R6 literal", rdata, 32'h0);
    wr(1, 1);
    look(3, "R6 sel1 unchanged");
    // R7: enable set/clear
    wr(4, 32'h3); wr(4, 32'h0);
    look(4, "R7 zero no effect");
    wr(5, 32'h1);
    look(5, "R7 clr");
    wr(4, 32'h7);
    // R9/R1: count random events
    evt_mode = 0;
    wr(0, 32'h1);
    idle(40);
    wr(1, 1); look(3, "R9 cnt1");
    wr(1, 2); look(3, "R9 cnt2");
    wr(1, 0); look(3, "R9 type out of range");
    wr(0, 32'h0);
    idle(20);
    wr(1, 1); look(3, "R1 held");
    look(10, "R1 cyc held");
    // R9/R10/R8: overflow
    evt_mode = 1;
    wr(3, 32'hFFFF_FFFE);
    wr(6, 32'h2);
    wr(0, 32'h1);
    idle(4);
    look(8, "R9 ovf flag");
    check("R10 irq high", 32'(irq), 32'd1);
    wr(0, 32'h0);
    idle(3);
    check("R10 irq held", 32'(irq), 32'd1);
    wr(9, 32'h2);
    check("R10 irq cleared", 32'(irq), 32'd0);
    wr(8, 32'h4); look(9, "R8 ovf set");
    check("R10 no ien", 32'(irq), 32'd0);
    wr(6, 32'h4); look(7, "R8 ien set");
    check("R10 ien path", 32'(irq), 32'd1);
    wr(7, 32'h4); look(6, "R8 ien clr");
    // R8: hardware wrap beats same-cycle clear
    wr(3, 32'hFFFF_FFFF);
    @(negedge clk); req = 1; we = 1; addr = 4'd0; wdata = 32'h1;
    @(negedge clk); addr = 4'd9; wdata = 32'h2;
    @(negedge clk); req = 0; we = 0;
    look(8, "R8 set beats clr");
    // R2: event clear strobe
    wr(0, 32'h3);
    look(3, "R2 evt cleared");
    // R3: prescaled cycle counter
    evt_mode = 2;
    wr(0, 32'hD);
    idle(200);
    look(10, "R3 div64");
    wr(0, 32'h5);
    idle(10);
    look(10, "R3 div off");
    look(11, "R11 hi");
    wr(0, 32'h4);
    look(10, "R2 cyc cleared");
    idle(2);
    finish_run();
  end
endmodule